// File: doc/BRIEF.md
# Selectable-Rate Hex Digit Flasher

This block cycles a 4-bit digit through the hexadecimal values 0 to F and drives one seven-segment display with the current value. The segment lines are active-low. A 2-bit speed select sets how fast the digit advances. One setting advances it on every clock. The other three settings use terminal counts that give, at a 50 MHz clock, one step per second, one step every two seconds and one step every four seconds.

Every register runs on the one system clock. The slower rates come from a down-counting divider. The divider is reloaded from the terminal count chosen by the select, and it raises a single-cycle step strobe while it holds zero. No divided clock is ever formed.

The three terminal counts are parameters, so a small simulation can use short periods. A synchronous active-low clear and a parallel load act on the digit counter. An asynchronous active-low reset is released on a clock edge by a two-stage synchronizer.

Top module: `hex_flasher`

## Requirements
- R1: During reset and for the two synchronizer cycles after reset is released, `count` is 0, `seg_n` is 7'h40 and `tick` is 0 when `sel` is not 00.
- R2: With `sel`=00 held, `tick` is high in every cycle except the first cycle in which 00 is sampled, and `count` advances once per clock.
- R3: With `sel` held at 01, 10 or 11, `tick` repeats every RELOAD_A+1, RELOAD_B+1 or RELOAD_C+1 cycles respectively.
- R4: Outside full speed, `tick` is never high in two consecutive cycles.
- R5: `count` increases by exactly one, wrapping from 15 to 0, on each edge at which `tick` is high and neither clear nor load is active. It holds its value at every other edge.
- R6: While `clr_n` is low, `tick` is low, and the next edge sets `count` to 0 even if `ld_en` is high. The divider restarts, so the first `tick` after release comes RELOAD cycles after the first edge with `clr_n` high.
- R7: When `ld_en` is high and `clr_n` is high, the next edge sets `count` to `ld_val` even if `tick` is high.
- R8: In the cycle where `sel` differs from its value at the previous edge, `tick` is low. The first `tick` of the new setting follows after that setting's full period, counted from the first edge that samples the new value.
- R9: `seg_n` bits 0..6 drive segments a..g, active-low, and show the usual hexadecimal glyphs for 0..F, with lower-case b and d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of digit and divider |
| sel | input | 2 | Speed select: 00 full, 01 slow A, 10 slow B, 11 slow C |
| ld_en | input | 1 | Parallel load strobe for the digit |
| ld_val | input | 4 | Value taken by the digit on load |
| count | output | 4 | Current digit |
| tick | output | 1 | Single-cycle step strobe from the divider |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
A divider that reloads the wrong count, or that misses its reload, moves the step strobe by one or more cycles. That shows at the very next expected strobe position. The counter also drifts from the model within one period. A restart that is missing after a select change or a clear shifts the first strobe of the new setting, so it is caught one period after the change. A wrong priority between clear, load and count, or a wrong glyph, is visible on `count` and `seg_n` at the edge right after the stimulus.

// File: rtl/hexflash_pkg.sv
package hexflash_pkg;

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_A    = 2'b01,
    SPD_B    = 2'b10,
    SPD_C    = 2'b11
  } speed_e;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;

  // Active-high pattern, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [SEG_W-1:0] glyph_on(input logic [DIGIT_W-1:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'h0: p = 7'b0111111;
      4'h1: p = 7'b0000110;
      4'h2: p = 7'b1011011;
      4'h3: p = 7'b1001111;
      4'h4: p = 7'b1100110;
      4'h5: p = 7'b1101101;
      4'h6: p = 7'b1111101;
      4'h7: p = 7'b0000111;
      4'h8: p = 7'b1111111;
      4'h9: p = 7'b1101111;
      4'hA: p = 7'b1110111;
      4'hB: p = 7'b1111100;
      4'hC: p = 7'b0111001;
      4'hD: p = 7'b1011110;
      4'hE: p = 7'b1111001;
      default: p = 7'b1110001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import hexflash_pkg::*;
#(
  parameter int unsigned RELOAD_A = 49_999_999,
  parameter int unsigned RELOAD_B = 99_999_999,
  parameter int unsigned RELOAD_C = 199_999_999
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_n,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int unsigned MAX_AB = (RELOAD_A > RELOAD_B) ? RELOAD_A : RELOAD_B;
  localparam int unsigned MAX_R  = (MAX_AB > RELOAD_C) ? MAX_AB : RELOAD_C;
  localparam int unsigned DIV_W  = (MAX_R < 2) ? 1 : $clog2(MAX_R + 1);

  logic [DIV_W-1:0] cnt_q, cnt_d, reload_v;
  logic [1:0]       sel_q;
  logic             restart, at_zero;

  // terminal count chosen by the select; full speed reloads zero
  always_comb begin
    case (speed_e'(sel))
      SPD_A:   reload_v = DIV_W'(RELOAD_A);
      SPD_B:   reload_v = DIV_W'(RELOAD_B);
      SPD_C:   reload_v = DIV_W'(RELOAD_C);
      default: reload_v = '0;
    endcase
  end

  always_comb begin
    restart = !clr_n || (sel != sel_q);
    at_zero = (cnt_q == '0);
    if (restart || at_zero) cnt_d = reload_v;
    else                    cnt_d = cnt_q - 1'b1;
    tick = at_zero && !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= SPD_FULL;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel;
    end
  end

endmodule

// File: rtl/digit_counter.sv
module digit_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         q_en;

  // priority: clear, then load, then step
  always_comb begin
    q_en = !clr_n || ld_en || step;
    if (!clr_n)     q_d = '0;
    else if (ld_en) q_d = ld_val;
    else            q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import hexflash_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output logic [SEG_W-1:0]   seg_n
);

  always_comb seg_n = ~glyph_on(digit);

endmodule

// File: rtl/hex_flasher.sv
module hex_flasher
  import hexflash_pkg::*;
#(
  parameter int unsigned RELOAD_A = 49_999_999,
  parameter int unsigned RELOAD_B = 99_999_999,
  parameter int unsigned RELOAD_C = 199_999_999,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic [1:0]         sel,
  input  logic               ld_en,
  input  logic [DIGIT_W-1:0] ld_val,
  output logic [DIGIT_W-1:0] count,
  output logic               tick,
  output logic [SEG_W-1:0]   seg_n
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  rate_divider #(
    .RELOAD_A(RELOAD_A),
    .RELOAD_B(RELOAD_B),
    .RELOAD_C(RELOAD_C)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr_n (clr_n),
    .sel   (sel),
    .tick  (tick)
  );

  digit_counter #(.W(DIGIT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_n  (clr_n),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .step   (tick),
    .q      (count)
  );

  seg_decoder u_seg (
    .digit (count),
    .seg_n (seg_n)
  );

endmodule

// File: rtl/hex_flasher_props.sv
module hex_flasher_props (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_n,
  input logic [1:0] sel,
  input logic       ld_en,
  input logic [3:0] ld_val,
  input logic [3:0] count,
  input logic       tick,
  input logic [6:0] seg_n
);

  p_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && $past(sel) == 2'b00 && clr_n) |-> tick);

  p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'b00) |=> !tick);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_en && tick) |=> count == 4'($past(count) + 4'd1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_en && !tick) |=> $stable(count));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> count == 4'd0);

  p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !tick);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_en) |=> count == $past(ld_val));

  p_sel_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !tick);

  p_glyph_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 4'd8) |-> seg_n == 7'h00);

endmodule

bind hex_flasher hex_flasher_props u_props (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .clr_n  (clr_n),
  .sel    (sel),
  .ld_en  (ld_en),
  .ld_val (ld_val),
  .count  (count),
  .tick   (tick),
  .seg_n  (seg_n)
);

// File: tb/hex_flasher_test.sv
`timescale 1ns/1ps
module hex_flasher_test;

  localparam int RA = 4;
  localparam int RB = 9;
  localparam int RC = 19;

  logic       clk = 1'b0;
  logic       rst_n, clr_n, ld_en;
  logic [1:0] sel;
  logic [3:0] ld_val;
  logic [3:0] count;
  logic       tick;
  logic [6:0] seg_n;

  int compared   = 0;
  int mismatched = 0;
  int cur        = 0;
  bit done       = 1'b0;

  always #10 clk = ~clk;

  hex_flasher #(.RELOAD_A(RA), .RELOAD_B(RB), .RELOAD_C(RC)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel(sel),
    .ld_en(ld_en), .ld_val(ld_val),
    .count(count), .tick(tick), .seg_n(seg_n)
  );

  function automatic int exp_seg(input int v);
    case (v)
      0: return 'h40;  1: return 'h79;  2: return 'h24;  3: return 'h30;
      4: return 'h19;  5: return 'h12;  6: return 'h02;  7: return 'h78;
      8: return 'h00;  9: return 'h10; 10: return 'h08; 11: return 'h03;
      12: return 'h46; 13: return 'h21; 14: return 'h06; default: return 'h0E;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // j counts edges from the first one that samples the new condition
  task automatic watch(input int n, input int off, input int c0, input int len,
                       input string tag);
    for (int j = 1; j <= len; j++) begin
      int ec;
      @(posedge clk); @(negedge clk);
      ec = (c0 + (j + off - 1) / n) % 16;
      chk(tag, "tick", int'(tick), ((j + off) % n == 0) ? 1 : 0);
      chk(tag, "count", int'(count), ec);
      chk("R9", "seg_n", int'(seg_n), exp_seg(ec));
    end
    cur = (c0 + (len + off - 1) / n) % 16;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; ld_en = 1'b0; ld_val = 4'd0; sel = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "count", int'(count), 0);
    chk("R1", "seg_n", int'(seg_n), 'h40);
    chk("R1", "tick", int'(tick), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R1", "count sync", int'(count), 0);
    end

    // R3 slow rates, each entered by a select change (R8)
    watch(RA + 1, 0, 0, 40, "R3");
    sel = 2'b10; watch(RB + 1, 0, cur, 45, "R3");
    sel = 2'b11; watch(RC + 1, 0, cur, 70, "R3");

    // R2 full speed, sweeps all glyphs and wraps
    sel = 2'b00; watch(1, 0, cur, 40, "R2");

    // R7 load wins over a live tick
    ld_val = 4'hE; ld_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", "count", int'(count), 14);
    ld_en = 1'b0;
    watch(1, 1, 14, 5, "R5");

    // R6 clear wins over load and silences tick
    sel = 2'b01; watch(RA + 1, 0, cur, 12, "R8");
    clr_n = 1'b0; ld_en = 1'b1; ld_val = 4'h9;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R6", "count", int'(count), 0);
      chk("R6", "tick", int'(tick), 0);
    end
    clr_n = 1'b1; ld_en = 1'b0;
    watch(RA + 1, 1, 0, 25, "R6");

    // R8 switch mid-period: new period starts from the change
    sel = 2'b11; watch(RC + 1, 0, cur, 7, "R8");
    sel = 2'b01; watch(RA + 1, 0, cur, 23, "R8");
    sel = 2'b10; watch(RB + 1, 0, cur, 3, "R8");
    sel = 2'b00; watch(1, 0, cur, 6, "R2");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule